// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single channel of a legacy-style interval timer. It holds a 16-bit down-counter that advances only on cycles where a slow count-enable pulse (`tick`) is high. The counter runs in one of two modes. The rate mode gives a periodic one-tick low pulse. The square-wave mode gives a continuous square wave whose period is the initial count in ticks.

Software sets up the channel through two ports. A control-word strobe selects the mode and the byte access order. An 8-bit data port loads the initial count and reads back the live count. The access order is one of three: low byte only, high byte only, or low byte followed by high byte. A read-back request captures a status byte, and the next data-port read returns that byte instead of the count.

A completed count write does not reach the counter at once. It is moved in on the first tick after the write. A gate input pauses counting while it is low.

Top module: `interval_channel`

## Requirements
- R1: After reset the output is high, the mode is rate, the access order is low-then-high, and the count reads as zero.
- R2: Control field `ctrlAccess` uses these codes. 01 means low byte only, and a data write then sets the low byte of the initial count and clears its high byte. 10 means high byte only, and a data write then sets the high byte and clears the low byte. 11 (and 00) means low byte then high byte.
- R3: In low-then-high order, the write pointer and the read pointer each alternate between the low byte and the high byte. Each starts at the low byte after every control-word write.
- R4: A data-port read returns the live count: the low byte, the high byte, or the two in turn, as selected by the access order.
- R5: A completed count write is moved into the counter on the first tick after the write. Until then the counter keeps its old value, and status bit 6 is 1.
- R6: A control-word write drives the output high on the next cycle and halts counting until a new count is loaded.
- R7: In rate mode with initial count N ≥ 2, the output is high for N−1 ticks after a load. It then goes low for exactly one tick when the count reaches 1, after which N is reloaded. The period is N ticks.
- R8: In square-wave mode the output is high right after a load. The count falls by two per tick. When it reaches zero the output inverts and the count reloads, so the output alternates indefinitely with a period of N ticks.
- R9: In square-wave mode with an odd N, the high half lasts (N+1)/2 ticks and the low half lasts (N−1)/2 ticks.
- R10: An initial count of 0 acts as 65536. The rate-mode output is high for 65535 ticks. In square-wave mode each half lasts 32768 ticks.
- R11: While `gate` is low, ticks do not change the count or the output.
- R12: A read-back strobe captures a status byte: bit 7 is the output, bit 6 is the load-pending flag, bits 5:4 are the access code, bits 3:1 are zero, and bit 0 is the mode (1 = square wave). The next data-port read returns this byte, and later reads return the count again.
- R13: In cycles where `tick` is low, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse |
| gate | input | 1 | Counting allowed when high |
| ctrlWr | input | 1 | Control-word write strobe |
| ctrlAccess | input | 2 | Access order code (see R2) |
| ctrlSquare | input | 1 | 1 selects square-wave mode, 0 selects rate mode |
| dataWr | input | 1 | Data-port write strobe |
| dataIn | input | 8 | Data-port write byte |
| dataRd | input | 1 | Data-port read strobe (advances the read sequence) |
| readBack | input | 1 | Capture the status byte for the next read |
| dataOut | output | 8 | Data-port read byte |
| outPin | output | 1 | Channel output |

## Verification
The rate mode is swept over every initial count from 2 to 9, and the square-wave mode over every count from 2 to 11. This separates the correct period from an off-by-one reload, and the odd-count split of the two halves from an even split. A zero count in both modes shows whether zero is treated as the full 65536-tick range. The three access orders are checked with byte values whose low and high halves differ, so a swapped byte or a dropped clear is visible. A stray byte written before a second control word shows whether the pointers restart. Reads of the count are taken before and after the first tick following a write, which exposes a load that happens too early or not at all.

// File: rtl/ictr_pkg.sv
package ictr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic {MODE_RATE = 1'b0, MODE_SQUARE = 1'b1} mode_e;

  typedef enum logic [1:0] {
    ACC_PAIR0 = 2'b00,
    ACC_LOW   = 2'b01,
    ACC_HIGH  = 2'b10,
    ACC_PAIR  = 2'b11
  } access_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // move initial count into the counter
    logic step;       // advance one tick in the current mode
    logic forceHigh;  // control word written
  } strobe_t;
endpackage

// File: rtl/ictr_ctrl.sv
module ictr_ctrl
  import ictr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              gate,
  input  logic              ctrlWr,
  input  logic [1:0]        ctrlAccess,
  input  logic              ctrlSquare,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              dataRd,
  input  logic              readBack,
  input  logic [CNT_W-1:0]  curCount,
  input  logic              outPin,
  output strobe_t           strb,
  output mode_e             mode,
  output logic [CNT_W-1:0]  initCount,
  output logic [BYTE_W-1:0] dataOut,
  output logic              running,
  output logic              pending
);
  access_e           access;
  logic              wrPtr, rdPtr, statusHeld;
  logic [BYTE_W-1:0] statusByte;
  logic              pairMode;

  assign pairMode = (access == ACC_PAIR) || (access == ACC_PAIR0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode       <= MODE_RATE;
      access     <= ACC_PAIR;
      wrPtr      <= 1'b0;
      rdPtr      <= 1'b0;
      initCount  <= '0;
      pending    <= 1'b0;
      running    <= 1'b0;
      statusHeld <= 1'b0;
      statusByte <= '0;
    end else if (ctrlWr) begin
      mode    <= ctrlSquare ? MODE_SQUARE : MODE_RATE;
      access  <= access_e'(ctrlAccess);
      wrPtr   <= 1'b0;
      rdPtr   <= 1'b0;
      pending <= 1'b0;
      running <= 1'b0;
    end else begin
      if (tick && pending) begin
        pending <= 1'b0;
        running <= 1'b1;
      end
      if (dataWr) begin
        case (access)
          ACC_LOW: begin
            initCount <= {{BYTE_W{1'b0}}, dataIn};
            pending   <= 1'b1;
          end
          ACC_HIGH: begin
            initCount <= {dataIn, {BYTE_W{1'b0}}};
            pending   <= 1'b1;
          end
          default: begin
            if (!wrPtr) begin
              initCount[BYTE_W-1:0] <= dataIn;
              wrPtr <= 1'b1;
            end else begin
              initCount[CNT_W-1:BYTE_W] <= dataIn;
              wrPtr   <= 1'b0;
              pending <= 1'b1;
            end
          end
        endcase
      end
      if (dataRd) begin
        if (statusHeld)    statusHeld <= 1'b0;
        else if (pairMode) rdPtr <= ~rdPtr;
      end
      if (readBack) begin
        statusHeld <= 1'b1;
        statusByte <= BYTE_W'({outPin, pending, access, 3'b000, mode});
      end
    end
  end

  always_comb begin
    strb.forceHigh = ctrlWr;
    strb.load      = tick && pending && !ctrlWr;
    strb.step      = tick && running && gate && !pending && !ctrlWr;
  end

  always_comb begin
    if (statusHeld)                          dataOut = statusByte;
    else if (access == ACC_HIGH)             dataOut = curCount[CNT_W-1:BYTE_W];
    else if (access == ACC_LOW || !rdPtr)    dataOut = curCount[BYTE_W-1:0];
    else                                     dataOut = curCount[CNT_W-1:BYTE_W];
  end
endmodule

// File: rtl/ictr_datapath.sv
module ictr_datapath
  import ictr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  mode_e            mode,
  input  logic [CNT_W-1:0] initCount,
  output logic [CNT_W-1:0] count,
  output logic             outPin
);
  // odd square-wave counts: longer high half, shorter low half
  function automatic logic [CNT_W-1:0] reloadFor(input logic highNext);
    if (mode == MODE_SQUARE && initCount[0])
      return highNext ? initCount + CNT_W'(1) : initCount - CNT_W'(1);
    return initCount;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      outPin <= 1'b1;
    end else if (strb.forceHigh) begin
      outPin <= 1'b1;
    end else if (strb.load) begin
      count  <= reloadFor(1'b1);
      outPin <= 1'b1;
    end else if (strb.step) begin
      if (mode == MODE_RATE) begin
        if (count == CNT_W'(1)) begin
          count  <= initCount;
          outPin <= 1'b1;
        end else begin
          count  <= count - CNT_W'(1);
          outPin <= (count != CNT_W'(2));
        end
      end else begin
        if (count == CNT_W'(2)) begin
          outPin <= ~outPin;
          count  <= reloadFor(~outPin);
        end else begin
          count <= count - CNT_W'(2);
        end
      end
    end
  end
endmodule

// File: rtl/interval_channel.sv
module interval_channel
  import ictr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       gate,
  input  logic       ctrlWr,
  input  logic [1:0] ctrlAccess,
  input  logic       ctrlSquare,
  input  logic       dataWr,
  input  logic [7:0] dataIn,
  input  logic       dataRd,
  input  logic       readBack,
  output logic [7:0] dataOut,
  output logic       outPin
);
  strobe_t          strb;
  mode_e            mode;
  logic [CNT_W-1:0] initCount, count;
  logic             running, pending;

  ictr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .gate(gate),
    .ctrlWr(ctrlWr), .ctrlAccess(ctrlAccess), .ctrlSquare(ctrlSquare),
    .dataWr(dataWr), .dataIn(dataIn), .dataRd(dataRd), .readBack(readBack),
    .curCount(count), .outPin(outPin), .strb(strb), .mode(mode),
    .initCount(initCount), .dataOut(dataOut), .running(running), .pending(pending)
  );

  ictr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(mode),
    .initCount(initCount), .count(count), .outPin(outPin)
  );
endmodule

// File: rtl/ictr_checker.sv
module ictr_checker
  import ictr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             gate,
  input logic             ctrlWr,
  input logic             outPin,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] initCount,
  input mode_e            mode,
  input logic             running,
  input logic             pending
);
  logic stepping;
  assign stepping = tick && gate && running && !pending && !ctrlWr;

  // R13
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(count));

  // R11
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!gate && !pending && !ctrlWr) |=> ($stable(count) && $stable(outPin)));

  // R6
  ctrl_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> outPin);

  // R7
  rate_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && mode == MODE_RATE && count == CNT_W'(1))
      |=> (outPin && count == $past(initCount)));

  // R8
  square_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && mode == MODE_SQUARE && count == CNT_W'(2))
      |=> (outPin != $past(outPin)));

  // R5
  load_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && pending && !ctrlWr) |=> (outPin && !pending));
endmodule

bind interval_channel ictr_checker u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .gate(gate), .ctrlWr(ctrlWr),
  .outPin(outPin), .count(count), .initCount(initCount), .mode(mode),
  .running(running), .pending(pending)
);

// File: tb/sim_interval_channel.sv
module sim_interval_channel;
  logic clk = 0, rstN = 0, tick = 0, gate = 1, ctrlWr = 0, ctrlSquare = 0;
  logic dataWr = 0, dataRd = 0, readBack = 0;
  logic [1:0] ctrlAccess = 2'b11;
  logic [7:0] dataIn = 0, dataOut;
  logic outPin;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  interval_channel u0 (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ctrl(logic [1:0] acc, logic sq);
    ctrlAccess = acc; ctrlSquare = sq; ctrlWr = 1;
    @(negedge clk); ctrlWr = 0;
  endtask

  task automatic wrByte(logic [7:0] b);
    dataIn = b; dataWr = 1;
    @(negedge clk); dataWr = 0;
  endtask

  task automatic rdByte(output int v);
    v = dataOut; dataRd = 1;
    @(negedge clk); dataRd = 0;
  endtask

  task automatic status(output int v);
    readBack = 1;
    @(negedge clk); readBack = 0;
    rdByte(v);
  endtask

  task automatic oneTick();
    tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic run(logic level, output int len);
    len = 0;
    while (outPin == level && len < 70000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic loadPair(int n, logic sq);
    ctrl(2'b11, sq);
    wrByte(n[7:0]);
    wrByte(n[15:8]);
    oneTick();
  endtask

  initial begin
    int v, w, hi, lo, hi2, full;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 out", outPin, 1);
    rdByte(v); check("R1 count lo", v, 0);
    rdByte(v); check("R1 count hi", v, 0);

    // R3 pointer restart on control write
    ctrl(2'b11, 0);
    wrByte(8'hAA);
    ctrl(2'b11, 0);
    wrByte(8'h34);
    wrByte(8'h12);
    status(v); check("R12 R5 status pending", v, 8'hF0);
    rdByte(v); check("R5 count not loaded", v, 0);
    rdByte(v);
    oneTick();
    status(v); check("R12 status loaded", v, 8'hB0);
    rdByte(v); check("R3 R4 lo", v, 8'h34);
    rdByte(v); check("R3 R4 hi", v, 8'h12);
    rdByte(v);
    ctrl(2'b11, 0);
    rdByte(v); check("R3 read ptr restart", v, 8'h34);

    // R2 single-byte orders
    ctrl(2'b01, 0); wrByte(8'h57); oneTick();
    rdByte(v); check("R2 R4 low only", v, 8'h57);
    ctrl(2'b10, 0);
    rdByte(v); check("R2 low-only cleared high", v, 0);
    wrByte(8'h03); oneTick();
    rdByte(v); check("R2 R4 high only", v, 8'h03);
    ctrl(2'b01, 0);
    rdByte(v); check("R2 high-only cleared low", v, 0);
    status(v); check("R12 status low-only rate", v, 8'h90);

    // R13, R11
    loadPair(16, 0);
    repeat (5) @(negedge clk);
    rdByte(v); rdByte(w); check("R13 no tick no change", v, 16);
    repeat (3) oneTick();
    rdByte(v); rdByte(w); check("R7 decrement", v, 13);
    gate = 0;
    repeat (2) oneTick();
    rdByte(v); rdByte(w); check("R11 gated", v, 13);
    gate = 1;

    // R7 rate sweep
    for (int n = 2; n <= 9; n++) begin
      loadPair(n, 0);
      tick = 1;
      run(1, hi); run(0, lo); run(1, hi2);
      tick = 0;
      check($sformatf("R7 n=%0d first high", n), hi, n - 1);
      check($sformatf("R7 n=%0d low", n), lo, 1);
      check($sformatf("R7 n=%0d period", n), hi2 + lo, n);
    end

    // R8/R9 square sweep
    for (int n = 2; n <= 11; n++) begin
      loadPair(n, 1);
      check($sformatf("R8 n=%0d starts high", n), outPin, 1);
      tick = 1;
      run(1, hi); run(0, lo); run(1, hi2);
      tick = 0;
      check($sformatf("R9 n=%0d high", n), hi, n - n / 2);
      check($sformatf("R9 n=%0d low", n), lo, n / 2);
      check($sformatf("R8 n=%0d period", n), hi2 + lo, n);
    end

    // R6 control write mid low phase
    loadPair(6, 1);
    tick = 1;
    run(1, hi);
    ctrl(2'b11, 1);
    check("R6 out forced high", outPin, 1);
    rdByte(v); rdByte(w);
    repeat (4) @(negedge clk);
    rdByte(hi); rdByte(hi2);
    check("R6 halted", hi, v);
    check("R6 still high", outPin, 1);
    tick = 0;

    // R10 zero count
    full = 65536;
    loadPair(0, 0);
    tick = 1; run(1, hi); run(0, lo); tick = 0;
    check("R10 rate high", hi, full - 1);
    check("R10 rate low", lo, 1);
    loadPair(0, 1);
    tick = 1; run(1, hi); run(0, lo); tick = 0;
    check("R10 square high", hi, full / 2);
    check("R10 square low", lo, full / 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule